// File: doc/BRIEF.md
# SCL Bit-Rate Generator

This block generates the clock line for the master side of a two-wire serial bus, working from the system clock. An 8-bit divisor register, which software can write and read back, sets the rate. Each SCL period is a low phase of (8 + N) system clocks followed by a high phase of (8 + N + E) clocks. N is the divisor value and E is an extra-cycles input that models bus alignment delay. The full period is therefore 16 + 2N + E clocks. Divisor values above seven are the ones for which correct bus operation is expected.

The block drives the line in open-drain style. `scl_drive_low` pulls SCL down, and releasing it lets the line float high. The block reads the real line level back on `scl_in`. The high phase counts only the clocks in which the line actually reads high, so another device holding SCL low delays the rising edge. A stall input, raised while software still has to service the interface, holds the line low for as long as it stays asserted. Both kinds of stretching lower the average bit rate.

A one-cycle `phase_tick` marks every edge the block drives, so a bit or byte sequencer can step in lockstep. When the enable is low, the block releases SCL and clears its phase counter. After that, the next enable always starts with a complete low phase.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset the divisor register reads 0, `scl_drive_low` is 0 and `phase_tick` is 0.
- R2: When `div_we` is high at a clock edge, `div_q` shows `div_wdata` from the next cycle onward.
- R3: While `enable` is low, `scl_drive_low` and `phase_tick` are 0 in the following cycle. When `enable` rises, SCL is pulled low one cycle later and a complete low phase starts.
- R4: With `stall` low, `scl_drive_low` stays high for exactly 8 + N consecutive cycles.
- R5: With SCL read back high, the released (high) phase lasts exactly 8 + N + E cycles, where E is `extra_cycles`.
- R6: Each clock edge at which `stall` is high during the low phase lengthens that phase by one cycle. `stall` has no effect on the length of the high phase.
- R7: Each clock edge in the high phase at which `scl_in` reads low lengthens that phase by one cycle, and SCL stays released during that time.
- R8: While enabled, `phase_tick` is high for exactly one cycle, namely the first cycle of each new level of `scl_drive_low`. Disabling the block produces no tick.
- R9: With no stretching, one full SCL period lasts 16 + 2N + E system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; low releases SCL and clears the counter |
| div_we | input | 1 | Write strobe for the divisor register |
| div_wdata | input | 8 | New divisor value N |
| div_q | output | 8 | Current divisor register contents |
| extra_cycles | input | 4 | Alignment clocks E added to each high phase |
| stall | input | 1 | Holds SCL low while software service is pending |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| phase_tick | output | 1 | One-cycle pulse at each driven SCL edge |

## Verification
A wrong phase counter shows up at the ports within the first SCL period. The low or high run of `scl_drive_low` comes out longer or shorter than 8 + N or 8 + N + E, and `phase_tick` pulses move along with it. Stretch faults, where a stall or held-low cycle is not counted or is counted twice, change the measured phase length by one cycle per affected edge in the very phase where they occur. A counter that is not cleared on disable appears as a short first low phase on the next enable. A faulty divisor register shows one cycle after the write on `div_q`.

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int DIV_W   = 8,
  parameter int EXTRA_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               div_we,
  input  logic [DIV_W-1:0]   div_wdata,
  output logic [DIV_W-1:0]   div_q,
  input  logic [EXTRA_W-1:0] extra_cycles,
  input  logic               stall,
  input  logic               scl_in,
  output logic               scl_drive_low,
  output logic               phase_tick
);

  localparam int MAX_HALF = 8 + (2**DIV_W - 1) + (2**EXTRA_W - 1);
  localparam int CW       = $clog2(MAX_HALF + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} phase_e;

  phase_e        state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] low_last, high_last;

  assign low_last  = CW'(div_q) + CW'(7);
  assign high_last = low_last + CW'(extra_cycles);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q         <= '0;
      state         <= S_IDLE;
      cnt           <= '0;
      scl_drive_low <= 1'b0;
      phase_tick    <= 1'b0;
    end else begin
      if (div_we) div_q <= div_wdata;
      phase_tick <= 1'b0;
      if (!enable) begin
        state         <= S_IDLE;
        cnt           <= '0;
        scl_drive_low <= 1'b0;
      end else begin
        unique case (state)
          S_IDLE: begin
            state         <= S_LOW;
            cnt           <= '0;
            scl_drive_low <= 1'b1;
            phase_tick    <= 1'b1;
          end
          S_LOW: begin
            if (!stall) begin
              if (cnt >= low_last) begin
                state         <= S_HIGH;
                cnt           <= '0;
                scl_drive_low <= 1'b0;
                phase_tick    <= 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          S_HIGH: begin
            if (scl_in) begin
              if (cnt >= high_last) begin
                state         <= S_LOW;
                cnt           <= '0;
                scl_drive_low <= 1'b1;
                phase_tick    <= 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R2
  div_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_we |=> div_q == $past(div_wdata));

  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_drive_low && !phase_tick));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && stall && state == S_LOW) |=> scl_drive_low);

  // R7
  slave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !scl_in && state == S_HIGH) |=> !scl_drive_low);

  // R8
  tick_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_tick |-> scl_drive_low != $past(scl_drive_low));

  // R8
  edge_has_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && scl_drive_low != $past(scl_drive_low)) |-> phase_tick);

  // R8
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_tick |=> !phase_tick);

endmodule

// File: tb/scl_rate_gen_bench.sv
module scl_rate_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       div_we = 1'b0;
  logic [7:0] div_wdata = '0;
  logic [7:0] div_q;
  logic [3:0] extra_cycles = '0;
  logic       stall = 1'b0;
  logic       hold = 1'b0;
  logic       scl_in;
  logic       scl_drive_low;
  logic       phase_tick;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;
  assign scl_in = !(scl_drive_low || hold);

  scl_rate_gen u_scl_rate_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_we(div_we),
    .div_wdata(div_wdata), .div_q(div_q), .extra_cycles(extra_cycles),
    .stall(stall), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .phase_tick(phase_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input logic lvl, output int len, output int ticks);
    len = 0; ticks = 0;
    while (scl_drive_low == lvl && len < 4000) begin
      len++;
      if (phase_tick) ticks++;
      @(negedge clk);
    end
  endtask

  task automatic setup(input int n, input int e);
    @(negedge clk);
    enable = 1'b0; div_we = 1'b1; div_wdata = 8'(n); extra_cycles = 4'(e);
    @(negedge clk);
    div_we = 1'b0;
    check(div_q == 8'(n), "R2 readback", int'(div_q), n);
    check(!scl_drive_low && !phase_tick, "R3 disabled", int'(scl_drive_low), 0);
    enable = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int lo, hi, tl, th, len, tk;
    repeat (3) @(negedge clk);
    check(div_q == 0, "R1 divisor", int'(div_q), 0);
    check(!scl_drive_low, "R1 drive", int'(scl_drive_low), 0);
    check(!phase_tick, "R1 tick", int'(phase_tick), 0);
    rst_n = 1'b1;

    for (int n = 0; n < 24; n++) begin
      for (int e = 0; e < 4; e++) begin
        setup(n, e);
        measure(1'b1, lo, tl);
        check(lo == 8 + n, "R4 low length", lo, 8 + n);
        check(tl == 1, "R8 low ticks", tl, 1);
        measure(1'b0, hi, th);
        check(hi == 8 + n + e, "R5 high length", hi, 8 + n + e);
        check(th == 1, "R8 high ticks", th, 1);
        check(lo + hi == 16 + 2*n + e, "R9 period", lo + hi, 16 + 2*n + e);
      end
    end

    // R6: stall in low phase adds one cycle per stalled edge; ignored in high phase
    setup(8, 0);
    len = 0;
    while (scl_drive_low && len < 4000) begin
      len++;
      if (len == 3) stall = 1'b1;
      if (len == 8) stall = 1'b0;
      @(negedge clk);
    end
    check(len == 21, "R6 stretched low", len, 21);
    stall = 1'b1;
    measure(1'b0, hi, th);
    stall = 1'b0;
    check(hi == 16, "R6 stall ignored in high", hi, 16);

    // R7: line held low by another device delays the high count
    setup(8, 0);
    len = 0;
    while (scl_drive_low && len < 4000) begin
      len++;
      if (len == 2) hold = 1'b1;
      @(negedge clk);
    end
    check(len == 16, "R7 low unaffected", len, 16);
    len = 0;
    while (!scl_drive_low && len < 4000) begin
      len++;
      if (len == 4) hold = 1'b0;
      @(negedge clk);
    end
    check(len == 19, "R7 held high phase", len, 19);

    // R3: disable mid-phase, then restart with a full low phase
    setup(10, 1);
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(!scl_drive_low && !phase_tick, "R3 release on disable", int'(scl_drive_low), 0);
    tk = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (phase_tick || scl_drive_low) tk++;
    end
    check(tk == 0, "R3 quiet while disabled", tk, 0);
    enable = 1'b1;
    @(negedge clk);
    check(phase_tick == 1'b1, "R8 tick on enable", int'(phase_tick), 1);
    measure(1'b1, lo, tl);
    check(lo == 18, "R3 full low after enable", lo, 18);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule